// File: doc/BRIEF.md
# Cache Tag-Array Maintenance Port

This block lets software maintain the tag array of a 4-way set-associative operand cache with 16-byte lines. Each request carries a 32-bit address field and a 32-bit data field. One address bit chooses between the tag array and the data array. Longword reads and writes of the data array go straight through. Tag-array reads return one way's packed entry.

Tag-array writes come in two modes. A direct write replaces every field of one chosen way. An associative write searches the valid ways of the indexed set for a tag and changes only the dirty and valid flags of the way that matches. The associative form is the usual way to invalidate or clean a single line by its address.

A line that is about to be overwritten or re-flagged while it holds dirty data is first copied to memory. The copy is a burst of four longword writes, each of which waits for its own acknowledge. The port refuses new requests until the burst ends and the tag update has been applied.

Top module: `ctm_port`

## Requirements
- R1: After reset every tag entry reads as zero (tag, LRU, U and V), `req_ready` is 1, and `mem_wr_valid` and `rsp_valid` are 0.
- R2: Address field layout: bit 31 selects the data array (1) or the tag array (0); bit 6+IDX_W is the associative bit; bits 5+IDX_W:4+IDX_W are the way; bits 3+IDX_W:4 are the set index; bits 3:2 are the longword within the line; bits 1:0 should be 00 and are ignored.
- R3: A data-array write stores the 32-bit data field at (index, way, longword). A data-array read returns that longword on `rsp_rdata`, with `rsp_valid` high in the cycle after acceptance.
- R4: A tag-array read returns the addressed way's entry packed as tag in bits 31:32-TAG_W, LRU in bits 1+LRU_W:2, U in bit 1 and V in bit 0, with the same timing as a data read.
- R5: A direct tag write (associative bit 0) replaces the tag, LRU, U and V of the addressed way with the data-field values, using the packing of R4. If that line was not both dirty and valid, the change takes effect at acceptance and causes no memory traffic.
- R6: A direct tag write to a line with U=1 and V=1 first writes the line back, then stores the new fields.
- R7: An associative tag write compares the data-field tag with the tags of the ways whose V is 1 in the indexed set, ignoring the way field. On a match only U and V of the lowest-numbered matching way change; its tag and LRU are kept.
- R8: An associative tag write that matches no valid way changes nothing and issues no memory write.
- R9: An associative tag write whose matching way has U=1 writes the line back before updating its flags.
- R10: Whenever the requested V is 0, U is stored as 0, whatever the data field holds.
- R11: A write-back issues four memory writes at {old tag, index, longword, 00} for longwords 0, 1, 2 and 3 in that order. Each write carries that longword of the line's data.
- R12: Each memory write holds its address and data until `mem_wr_ack`. `req_ready` stays 0 from acceptance until the last acknowledge, and returns to 1 in the next cycle with the update applied.
- R13: Data-array reads and writes never change the tag array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Maintenance request present |
| req_ready | output | 1 | Port can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Address field (layout in R2) |
| req_wdata | input | 32 | Data field: a longword for the data array, or a packed entry for the tag array (R4) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| mem_wr_valid | output | 1 | Write-back longword pending |
| mem_wr_addr | output | 32 | Write-back byte address |
| mem_wr_data | output | 32 | Write-back data |
| mem_wr_ack | input | 1 | Memory accepted the pending longword |

## Verification
The bench sweeps every set and way through a series of direct and associative writes. It gets the memory acknowledge after a varying delay, and predicts each write-back from a model of the arrays. It targets several cases:
- A port that skipped the write-back for a dirty line, or wrote one for a clean line, shows a wrong burst count.
- A port that formed the burst address from the new tag instead of the old one shows wrong memory addresses.
- A port that let invalid ways match, or picked a higher way when two valid ways hold the same tag, updates the wrong entry, and the readback reveals it.
- A port that kept U when V was cleared, or let data-array traffic disturb the tag array, is caught by readback after the operation.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
   localparam int CTM_WAYS   = 4;
   localparam int CTM_WAY_W  = 2;
   localparam int CTM_WORDS  = 4;
   localparam int CTM_WORD_W = 2;
   localparam int CTM_OFS_W  = 4;

   typedef enum logic [1:0] {
      UPD_NONE  = 2'd0,
      UPD_FULL  = 2'd1,
      UPD_FLAGS = 2'd2
   } upd_kind_e;
endpackage

// File: rtl/ctm_tag_store.sv
module ctm_tag_store
   import ctm_pkg::*;
#(
   parameter int SETS  = 16,
   parameter int IDX_W = 4,
   parameter int TAG_W = 24,
   parameter int LRU_W = 6
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [IDX_W-1:0]                     rd_idx,
   output logic [CTM_WAYS-1:0][TAG_W-1:0]       rd_tag,
   output logic [CTM_WAYS-1:0][LRU_W-1:0]       rd_lru,
   output logic [CTM_WAYS-1:0]                  rd_u,
   output logic [CTM_WAYS-1:0]                  rd_v,
   input  logic                                 wr_en,
   input  logic                                 wr_flags_only,
   input  logic [IDX_W-1:0]                     wr_idx,
   input  logic [CTM_WAY_W-1:0]                 wr_way,
   input  logic [TAG_W-1:0]                     wr_tag,
   input  logic [LRU_W-1:0]                     wr_lru,
   input  logic                                 wr_u,
   input  logic                                 wr_v
);
   for (genvar w = 0; w < CTM_WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tag_q [SETS];
      logic [LRU_W-1:0] lru_q [SETS];
      logic [SETS-1:0]  u_q;
      logic [SETS-1:0]  v_q;
      logic             sel;

      assign sel = wr_en && (wr_way == CTM_WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
               tag_q[s] <= '0;
               lru_q[s] <= '0;
            end
            u_q <= '0;
            v_q <= '0;
         end else if (sel) begin
            if (!wr_flags_only) begin
               tag_q[wr_idx] <= wr_tag;
               lru_q[wr_idx] <= wr_lru;
            end
            u_q[wr_idx] <= wr_u;
            v_q[wr_idx] <= wr_v;
         end
      end

      assign rd_tag[w] = tag_q[rd_idx];
      assign rd_lru[w] = lru_q[rd_idx];
      assign rd_u[w]   = u_q[rd_idx];
      assign rd_v[w]   = v_q[rd_idx];
   end
endmodule

// File: rtl/ctm_way_match.sv
module ctm_way_match
   import ctm_pkg::*;
#(
   parameter int TAG_W = 24
) (
   input  logic [CTM_WAYS-1:0][TAG_W-1:0] way_tag,
   input  logic [CTM_WAYS-1:0]            way_v,
   input  logic [TAG_W-1:0]               key,
   output logic                           hit,
   output logic [CTM_WAY_W-1:0]           hit_way
);
   logic [CTM_WAYS-1:0] eq;

   for (genvar w = 0; w < CTM_WAYS; w++) begin : g_cmp
      assign eq[w] = way_v[w] && (way_tag[w] == key);
   end

   assign hit = |eq;

   always_comb begin
      hit_way = '0;
      for (int w = CTM_WAYS - 1; w >= 0; w--) begin
         if (eq[w]) hit_way = CTM_WAY_W'(w);
      end
   end
endmodule

// File: rtl/ctm_data_store.sv
module ctm_data_store
   import ctm_pkg::*;
#(
   parameter int SETS       = 16,
   parameter int IDX_W      = 4,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [IDX_W-1:0]      a_idx,
   input  logic [CTM_WAY_W-1:0]  a_way,
   input  logic [CTM_WORD_W-1:0] a_word,
   input  logic                  a_we,
   input  logic [31:0]           a_wdata,
   output logic [31:0]           a_rdata,
   input  logic [IDX_W-1:0]      b_idx,
   input  logic [CTM_WAY_W-1:0]  b_way,
   input  logic [CTM_WORD_W-1:0] b_word,
   output logic [31:0]           b_rdata
);
   localparam int DEPTH = SETS * CTM_WAYS * CTM_WORDS;
   localparam int ADR_W = IDX_W + CTM_WAY_W + CTM_WORD_W;

   logic [31:0]      mem [DEPTH];
   logic [ADR_W-1:0] a_adr;
   logic [ADR_W-1:0] b_adr;

   assign a_adr = {a_idx, a_way, a_word};
   assign b_adr = {b_idx, b_way, b_word};

   if (RESET_DATA) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (a_we) begin
            mem[a_adr] <= a_wdata;
         end
      end
   end else begin : g_plain
      logic rst_unused;
      assign rst_unused = rst_n;
      always_ff @(posedge clk) begin
         if (a_we) mem[a_adr] <= a_wdata;
      end
   end

   assign a_rdata = mem[a_adr];
   assign b_rdata = mem[b_adr];
endmodule

// File: rtl/ctm_wb_seq.sv
module ctm_wb_seq
   import ctm_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  ack,
   output logic                  busy,
   output logic [CTM_WORD_W-1:0] word,
   output logic                  done
);
   localparam logic [CTM_WORD_W-1:0] LAST = CTM_WORD_W'(CTM_WORDS - 1);

   assign done = busy && ack && (word == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         word <= '0;
      end else if (start) begin
         busy <= 1'b1;
         word <= '0;
      end else if (busy && ack) begin
         if (word == LAST) busy <= 1'b0;
         else              word <= word + 1'b1;
      end
   end
endmodule

// File: rtl/ctm_port.sv
module ctm_port
   import ctm_pkg::*;
#(
   parameter int SETS       = 16,
   parameter int LRU_W      = 6,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic        req_write,
   input  logic [31:0] req_addr,
   input  logic [31:0] req_wdata,
   output logic        rsp_valid,
   output logic [31:0] rsp_rdata,
   output logic        mem_wr_valid,
   output logic [31:0] mem_wr_addr,
   output logic [31:0] mem_wr_data,
   input  logic        mem_wr_ack
);
   localparam int IDX_W     = $clog2(SETS);
   localparam int TAG_W     = 32 - CTM_OFS_W - IDX_W;
   localparam int IDX_LSB   = CTM_OFS_W;
   localparam int WAY_LSB   = IDX_LSB + IDX_W;
   localparam int ASSOC_BIT = WAY_LSB + CTM_WAY_W;
   localparam int ARR_BIT   = 31;

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("ctm_port: SETS must be a power of two of at least 2");
   end
   if (LRU_W < 1 || LRU_W + 2 > CTM_OFS_W + IDX_W) begin : g_bad_lru
      $error("ctm_port: LRU_W does not fit below the tag field");
   end
   if (ASSOC_BIT >= ARR_BIT) begin : g_bad_idx
      $error("ctm_port: index too wide for the address field");
   end

   // request field decode
   logic                  f_arr, f_assoc;
   logic [CTM_WAY_W-1:0]  f_way;
   logic [IDX_W-1:0]      f_idx;
   logic [CTM_WORD_W-1:0] f_word;
   logic [TAG_W-1:0]      n_tag;
   logic [LRU_W-1:0]      n_lru;
   logic                  n_u, n_v;
   logic                  addr_unused;

   assign f_arr   = req_addr[ARR_BIT];
   assign f_assoc = req_addr[ASSOC_BIT];
   assign f_way   = req_addr[WAY_LSB +: CTM_WAY_W];
   assign f_idx   = req_addr[IDX_LSB +: IDX_W];
   assign f_word  = req_addr[2 +: CTM_WORD_W];
   assign n_tag   = req_wdata[31 -: TAG_W];
   assign n_lru   = req_wdata[2 +: LRU_W];
   assign n_v     = req_wdata[0];
   assign n_u     = req_wdata[1] & req_wdata[0];
   assign addr_unused = ^{req_addr[ARR_BIT-1:ASSOC_BIT+1], req_addr[1:0]};

   // submodule wiring
   logic [CTM_WAYS-1:0][TAG_W-1:0] ts_tag;
   logic [CTM_WAYS-1:0][LRU_W-1:0] ts_lru;
   logic [CTM_WAYS-1:0]            ts_u, ts_v;
   logic                           st_en, st_flags;
   logic [IDX_W-1:0]               st_idx;
   logic [CTM_WAY_W-1:0]           st_way;
   logic [TAG_W-1:0]               st_tag;
   logic [LRU_W-1:0]               st_lru;
   logic                           st_u, st_v;
   logic                           hit;
   logic [CTM_WAY_W-1:0]           hit_way;
   logic [31:0]                    ds_rdata;
   logic                           seq_busy, seq_done;
   logic [CTM_WORD_W-1:0]          seq_word;

   // write-back and deferred update state
   logic [TAG_W-1:0]     wb_tag;
   logic [IDX_W-1:0]     wb_idx;
   logic [CTM_WAY_W-1:0] wb_way;
   upd_kind_e            pend_kind;
   logic [TAG_W-1:0]     pend_tag;
   logic [LRU_W-1:0]     pend_lru;
   logic                 pend_u, pend_v;

   // operation decision in the acceptance cycle
   logic                 accept, tag_wr_req, op_dirty, start_wb, imm;
   logic [CTM_WAY_W-1:0] op_way;
   upd_kind_e            op_kind;

   assign req_ready  = !seq_busy;
   assign accept     = req_valid && req_ready;
   assign tag_wr_req = accept && req_write && !f_arr;
   assign op_way     = f_assoc ? hit_way : f_way;

   always_comb begin
      if (!tag_wr_req)  op_kind = UPD_NONE;
      else if (!f_assoc) op_kind = UPD_FULL;
      else if (hit)      op_kind = UPD_FLAGS;
      else               op_kind = UPD_NONE;
   end

   assign op_dirty = ts_u[op_way] && ts_v[op_way];
   assign start_wb = (op_kind != UPD_NONE) && op_dirty;
   assign imm      = (op_kind != UPD_NONE) && !op_dirty;

   always_comb begin
      st_en = imm || seq_done;
      if (seq_done) begin
         st_flags = (pend_kind == UPD_FLAGS);
         st_idx   = wb_idx;
         st_way   = wb_way;
         st_tag   = pend_tag;
         st_lru   = pend_lru;
         st_u     = pend_u;
         st_v     = pend_v;
      end else begin
         st_flags = (op_kind == UPD_FLAGS);
         st_idx   = f_idx;
         st_way   = op_way;
         st_tag   = n_tag;
         st_lru   = n_lru;
         st_u     = n_u;
         st_v     = n_v;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_tag    <= '0;
         wb_idx    <= '0;
         wb_way    <= '0;
         pend_kind <= UPD_NONE;
         pend_tag  <= '0;
         pend_lru  <= '0;
         pend_u    <= 1'b0;
         pend_v    <= 1'b0;
      end else if (start_wb) begin
         wb_tag    <= ts_tag[op_way];
         wb_idx    <= f_idx;
         wb_way    <= op_way;
         pend_kind <= op_kind;
         pend_tag  <= n_tag;
         pend_lru  <= n_lru;
         pend_u    <= n_u;
         pend_v    <= n_v;
      end
   end

   // read response
   logic [31:0] tag_word;
   always_comb begin
      tag_word              = '0;
      tag_word[31 -: TAG_W] = ts_tag[f_way];
      tag_word[2 +: LRU_W]  = ts_lru[f_way];
      tag_word[1]           = ts_u[f_way];
      tag_word[0]           = ts_v[f_way];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= accept && !req_write;
         if (accept && !req_write) rsp_rdata <= f_arr ? ds_rdata : tag_word;
      end
   end

   // memory side
   always_comb begin
      mem_wr_addr                     = '0;
      mem_wr_addr[31 -: TAG_W]        = wb_tag;
      mem_wr_addr[IDX_LSB +: IDX_W]   = wb_idx;
      mem_wr_addr[2 +: CTM_WORD_W]    = seq_word;
   end
   assign mem_wr_valid = seq_busy;

   ctm_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .LRU_W(LRU_W)) tags_i (
      .clk(clk), .rst_n(rst_n), .rd_idx(f_idx),
      .rd_tag(ts_tag), .rd_lru(ts_lru), .rd_u(ts_u), .rd_v(ts_v),
      .wr_en(st_en), .wr_flags_only(st_flags), .wr_idx(st_idx), .wr_way(st_way),
      .wr_tag(st_tag), .wr_lru(st_lru), .wr_u(st_u), .wr_v(st_v)
   );

   ctm_way_match #(.TAG_W(TAG_W)) match_i (
      .way_tag(ts_tag), .way_v(ts_v), .key(n_tag), .hit(hit), .hit_way(hit_way)
   );

   ctm_data_store #(.SETS(SETS), .IDX_W(IDX_W), .RESET_DATA(RESET_DATA)) data_i (
      .clk(clk), .rst_n(rst_n),
      .a_idx(f_idx), .a_way(f_way), .a_word(f_word),
      .a_we(accept && req_write && f_arr), .a_wdata(req_wdata), .a_rdata(ds_rdata),
      .b_idx(wb_idx), .b_way(wb_way), .b_word(seq_word), .b_rdata(mem_wr_data)
   );

   ctm_wb_seq seq_i (
      .clk(clk), .rst_n(rst_n), .start(start_wb), .ack(mem_wr_ack),
      .busy(seq_busy), .word(seq_word), .done(seq_done)
   );
endmodule

// File: rtl/ctm_port_chk.sv
module ctm_port_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_ready,
   input logic        req_write,
   input logic        rsp_valid,
   input logic        mem_wr_valid,
   input logic [31:0] mem_wr_addr,
   input logic        mem_wr_ack
);
   AST_NO_MEM_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_wr_valid); // R12

   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid && !mem_wr_ack |=> mem_wr_valid && $stable(mem_wr_addr)); // R12

   AST_READY_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid && mem_wr_ack && mem_wr_addr[3:2] == 2'd3 |=> req_ready && !mem_wr_valid); // R12

   AST_BURST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid && mem_wr_ack && mem_wr_addr[3:2] != 2'd3 |=>
         mem_wr_valid && mem_wr_addr[3:2] == $past(mem_wr_addr[3:2]) + 2'd1
         && mem_wr_addr[31:4] == $past(mem_wr_addr[31:4])); // R11

   AST_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_valid) |-> mem_wr_addr[3:0] == 4'h0); // R11

   AST_LONG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> mem_wr_addr[1:0] == 2'b00); // R11

   AST_RSP_FOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_ready && !req_write)); // R3
endmodule

bind ctm_port ctm_port_chk chk_i (.*);

// File: tb/ctm_port_tb_top.sv
module ctm_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        mem_wr_valid;
   logic [31:0] mem_wr_addr;
   logic [31:0] mem_wr_data;
   logic        mem_wr_ack = 1'b0;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   ctm_port dut_i (.*);

   // reference model of the arrays (defaults: 16 sets, 24-bit tag, 6-bit LRU)
   logic [23:0] m_tag  [16][4];
   logic [5:0]  m_lru  [16][4];
   bit          m_u    [16][4];
   bit          m_v    [16][4];
   logic [31:0] m_data [16][4][4];

   // memory responder with varying latency and a write log
   logic [31:0] log_addr [4096];
   logic [31:0] log_data [4096];
   int          log_n = 0;
   int          lat_cnt = 0;
   int          busy_ready_viol = 0;

   always @(posedge clk) begin
      if (mem_wr_valid && req_ready) busy_ready_viol <= busy_ready_viol + 1;
      if (mem_wr_ack) begin
         mem_wr_ack <= 1'b0;
      end else if (mem_wr_valid) begin
         if (lat_cnt >= (log_n % 3)) begin
            mem_wr_ack <= 1'b1;
            if (log_n < 4096) begin
               log_addr[log_n] <= mem_wr_addr;
               log_data[log_n] <= mem_wr_data;
            end
            log_n   <= log_n + 1;
            lat_cnt <= 0;
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_addr(bit arr, bit assoc, int way, int idx, int word);
      logic [31:0] a;
      a       = '0;
      a[31]   = arr;
      a[10]   = assoc;
      a[9:8]  = way[1:0];
      a[7:4]  = idx[3:0];
      a[3:2]  = word[1:0];
      return a;
   endfunction

   function automatic logic [31:0] mk_entry(logic [23:0] tag, logic [5:0] lru, bit u, bit v);
      return {tag, lru, u, v};
   endfunction

   function automatic logic [31:0] dpat(logic [31:0] seed, int i, int w, int k);
      return seed ^ (i * 32'h0101_0103) ^ (w << 20) ^ (k << 28) ^ (k * 7);
   endfunction

   task automatic do_req(input bit wr, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output bit rv);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      @(negedge clk);
      rv        = rsp_valid;
      rd        = rsp_rdata;
      req_valid = 1'b0;
      while (!req_ready) @(negedge clk);
   endtask

   task automatic data_write(int i, int w, int k, logic [31:0] val);
      logic [31:0] rd;
      bit rv;
      do_req(1'b1, mk_addr(1'b1, 1'b0, w, i, k), val, rd, rv);
      m_data[i][w][k] = val;
   endtask

   task automatic data_read_check(int i, int w, int k, logic [1:0] low);
      logic [31:0] rd;
      bit rv;
      do_req(1'b0, mk_addr(1'b1, 1'b0, w, i, k) | {30'b0, low}, 32'h0, rd, rv);
      chk_eq("R3", {31'b0, rv}, 32'd1);
      if (low != 2'b00) chk_eq("R2", rd, m_data[i][w][k]);
      else              chk_eq("R3", rd, m_data[i][w][k]);
   endtask

   task automatic tag_read_check(int i, int w, string lbl);
      logic [31:0] rd;
      bit rv;
      do_req(1'b0, mk_addr(1'b0, 1'b0, w, i, 0), 32'h0, rd, rv);
      chk_eq("R4", {31'b0, rv}, 32'd1);
      chk_eq(lbl, rd, mk_entry(m_tag[i][w], m_lru[i][w], m_u[i][w], m_v[i][w]));
   endtask

   task automatic tag_write(bit assoc, int idx, int way, logic [23:0] tag,
                            logic [5:0] lru, bit u, bit v);
      int          tw;
      bit          wb;
      logic [23:0] old_tag;
      int          base;
      logic [31:0] rd;
      bit          rv;
      tw = -1;
      wb = 1'b0;
      old_tag = '0;
      if (!assoc) begin
         tw = way;
         wb = m_u[idx][way] && m_v[idx][way];
      end else begin
         for (int w = 3; w >= 0; w--)
            if (m_v[idx][w] && m_tag[idx][w] == tag) tw = w;
         if (tw >= 0) wb = m_u[idx][tw];
      end
      if (tw >= 0) old_tag = m_tag[idx][tw];
      base = log_n;
      do_req(1'b1, mk_addr(1'b0, assoc, way, idx, 0), mk_entry(tag, lru, u, v), rd, rv);
      chk_eq(assoc ? "R9" : "R6", log_n - base, wb ? 32'd4 : 32'd0);
      if (wb && base + 4 <= 4096) begin
         for (int k = 0; k < 4; k++) begin
            chk_eq("R11", log_addr[base + k], {old_tag, idx[3:0], k[1:0], 2'b00});
            chk_eq("R11", log_data[base + k], m_data[idx][tw][k]);
         end
      end
      if (tw >= 0) begin
         if (!assoc) begin
            m_tag[idx][tw] = tag;
            m_lru[idx][tw] = lru;
         end
         m_u[idx][tw] = u & v;
         m_v[idx][tw] = v;
      end
      for (int w = 0; w < 4; w++)
         tag_read_check(idx, w, !assoc ? "R5" : (tw >= 0 ? "R7" : "R8"));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      bit          rv;
      logic [23:0] dup;
      for (int i = 0; i < 16; i++)
         for (int w = 0; w < 4; w++) begin
            m_tag[i][w] = '0; m_lru[i][w] = '0; m_u[i][w] = 0; m_v[i][w] = 0;
            for (int k = 0; k < 4; k++) m_data[i][w][k] = '0;
         end

      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R1", {31'b0, req_ready}, 32'd1);
      chk_eq("R1", {31'b0, mem_wr_valid}, 32'd0);
      chk_eq("R1", {31'b0, rsp_valid}, 32'd0);
      for (int i = 0; i < 16; i++)
         for (int w = 0; w < 4; w++) tag_read_check(i, w, "R1");

      // R3: data array sweep, R2: low address bits ignored
      for (int i = 0; i < 16; i++)
         for (int w = 0; w < 4; w++)
            for (int k = 0; k < 4; k++) data_write(i, w, k, dpat(32'h3C5A_0F00, i, w, k));
      for (int i = 0; i < 16; i++)
         for (int w = 0; w < 4; w++)
            for (int k = 0; k < 4; k++) data_read_check(i, w, k, 2'(k ^ i));

      // R5: direct writes, clean lines
      for (int i = 0; i < 16; i++)
         for (int w = 0; w < 4; w++)
            tag_write(1'b0, i, w, 24'hC0_0000 | 24'(i << 8) | 24'(w << 4) | 24'd1,
                      6'((i * 4 + w) & 63), 1'b0, 1'b1);

      // R13: data traffic leaves the tag array alone
      for (int i = 0; i < 16; i++)
         for (int w = 0; w < 4; w++)
            for (int k = 0; k < 4; k++) data_write(i, w, k, dpat(32'h9E37_79B9, i, w, k));
      for (int i = 0; i < 16; i++)
         for (int w = 0; w < 4; w++) begin
            data_read_check(i, w, 0, 2'b00);
            tag_read_check(i, w, "R13");
         end

      // R10: U forced to 0 when V is written 0
      tag_write(1'b0, 3, 2, 24'h00_1234, 6'h2A, 1'b1, 1'b0);
      do_req(1'b0, mk_addr(1'b0, 1'b0, 2, 3, 0), 32'h0, rd, rv);
      chk_eq("R10", {31'b0, rd[1]}, 32'd0);

      // make every line dirty, then overwrite all: each overwrite writes back (R6)
      for (int i = 0; i < 16; i++)
         for (int w = 0; w < 4; w++)
            tag_write(1'b0, i, w, 24'hA5_0000 ^ 24'(i << 12) ^ 24'(w << 2), 6'(63 - i), 1'b1, 1'b1);
      for (int i = 0; i < 16; i++)
         for (int w = 0; w < 4; w++)
            tag_write(1'b0, i, w, 24'h5A_0F00 ^ 24'(i << 16) ^ 24'(w * 3), 6'(i + w), 1'((i + w) % 2), 1'b1);

      // R7/R9: associative hits on every way (way field ignored)
      for (int i = 0; i < 16; i++)
         for (int w = 0; w < 4; w++)
            tag_write(1'b1, i, (w + 1) % 4, m_tag[i][w], 6'h15, 1'b1, 1'(w != 2));

      // R8: associative misses
      for (int i = 0; i < 16; i++) tag_write(1'b1, i, i % 4, 24'hFF_FFFF, 6'h3F, 1'b1, 1'b1);

      // R7: a way with V=0 never matches (way 2 was invalidated above)
      for (int i = 0; i < 16; i += 3) tag_write(1'b1, i, 0, m_tag[i][2], 6'h01, 1'b1, 1'b1);

      // R7: duplicate tags, lowest valid way wins
      dup = 24'h77_7770;
      tag_write(1'b0, 9, 3, dup, 6'h11, 1'b0, 1'b1);
      tag_write(1'b0, 9, 1, dup, 6'h22, 1'b1, 1'b1);
      tag_write(1'b0, 9, 0, 24'h00_0001, 6'h33, 1'b1, 1'b1);
      tag_write(1'b1, 9, 2, dup, 6'h00, 1'b0, 1'b1);
      do_req(1'b0, mk_addr(1'b0, 1'b0, 1, 9, 0), 32'h0, rd, rv);
      chk_eq("R7", rd, mk_entry(dup, 6'h22, 1'b0, 1'b1));
      do_req(1'b0, mk_addr(1'b0, 1'b0, 3, 9, 0), 32'h0, rd, rv);
      chk_eq("R7", rd, mk_entry(dup, 6'h11, 1'b0, 1'b1));

      // R12: ready never high while a burst is pending
      @(negedge clk);
      chk_eq("R12", busy_ready_viol, 32'd0);
      chk_eq("R12", {31'b0, req_ready}, 32'd1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule